// File: doc/BRIEF.md
# Count-Compare Interval Timer

This block provides a free-running tick counter and a programmable match register for a processor's exception unit. Both registers sit on the same numbered register port the exception unit already uses: register number 9 holds the counter and register number 11 holds the match value. The counter advances once every `PRESCALE` clock cycles, whatever software is doing.

When the counter steps onto the value held in the match register, the block raises a timer interrupt request. The request stays high until software writes the match register. The exception unit reports this request as bit 15 of its cause register.

To schedule the next interrupt, software reads the counter, adds an interval and writes the sum to the match register. A shorter interval gives an earlier interrupt. Writing the match register also acknowledges the pending request.

Top module: `tick_match_timer`

## Requirements
- R1: While reset is asserted, the counter reads 0, the match register reads 0 and `timerIrq` is low.
- R2: The counter increments by one every `PRESCALE` clock cycles. Writing the counter (register number 9) loads the written value and restarts the prescaler, so the next increment comes `PRESCALE` cycles after that write.
- R3: The counter wraps from 0xFFFFFFFF to 0x00000000 and keeps counting.
- R4: `regRdData` shows the counter when `regAddr` is 9 and the match register when `regAddr` is 11, in the same cycle with no latency. Any other register number reads as 0.
- R5: A write to register number 11 stores any 32-bit value, and that value reads back unchanged.
- R6: `timerIrq` rises on the clock edge at which the counter steps to a value equal to the match register. The counter is written with K and the match register holds K+n. Then `timerIrq` rises exactly n×`PRESCALE` cycles after the counter write.
- R7: Once raised, `timerIrq` stays high while the counter moves on. A write to register number 11 clears it on that write's clock edge.
- R8: If a match-register write falls in the same cycle as a counter step onto the match value, the write wins: `timerIrq` is cleared and not set.
- R9: A counter write never raises `timerIrq` in its own cycle. This holds when the written value equals the match value, and when a prescaler step onto the match value is pending in that cycle.
- R10: Writes to any register number other than 9 and 11 change neither register nor `timerIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W (5) | Register number for read and write |
| regWrData | input | DATA_W (32) | Write data |
| regRdData | output | DATA_W (32) | Combinational read data for `regAddr` |
| timerIrq | output | 1 | Sticky timer interrupt request (cause bit 15) |

## Verification
The bench aims at the cycle-exact edges of the match. It checks the interrupt one cycle before and exactly on the n×PRESCALE boundary, so a design that compared against the old counter value or used the prescaler phase wrongly would fire one step early or late. It forces collisions: a match-register write on the very edge of a match, and a counter write on an edge where the prescaler would have stepped onto the match value. A design with the wrong priority would leave a spurious pending request in either case. It also crosses the 0xFFFFFFFF wrap, writes an unmapped register number, and watches the request stay high long after the match, which catches a pulse-only or equality-level interrupt.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  localparam int REG_NUM_COUNT   = 9;
  localparam int REG_NUM_COMPARE = 11;
  localparam int CAUSE_TIMER_BIT = 15;

  typedef enum logic [1:0] {
    RD_NONE    = 2'd0,
    RD_COUNT   = 2'd1,
    RD_COMPARE = 2'd2
  } rd_sel_e;

  typedef struct packed {
    logic    tick;
    logic    countLoad;
    logic    compareLoad;
    rd_sel_e rdSel;
  } tmr_strobe_t;

endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output tmr_strobe_t       strobe
);

  localparam int              DIV_W    = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(PRESCALE - 1);
  localparam logic [ADDR_W-1:0] ADDR_COUNT   = ADDR_W'(REG_NUM_COUNT);
  localparam logic [ADDR_W-1:0] ADDR_COMPARE = ADDR_W'(REG_NUM_COMPARE);

  logic [DIV_W-1:0] divCnt;
  logic             selCount;
  logic             selCompare;
  logic             tickNow;

  always_comb begin
    selCount   = (regAddr == ADDR_COUNT);
    selCompare = (regAddr == ADDR_COMPARE);
    tickNow    = (divCnt == DIV_LAST);
  end

  // prescaler: a counter load restarts the phase so the next step is PRESCALE cycles away
  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if ((regWrEn && selCount) || tickNow) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end

  always_comb begin
    strobe.tick        = tickNow;
    strobe.countLoad   = regWrEn && selCount;
    strobe.compareLoad = regWrEn && selCompare;
    if (selCount) begin
      strobe.rdSel = RD_COUNT;
    end else if (selCompare) begin
      strobe.rdSel = RD_COMPARE;
    end else begin
      strobe.rdSel = RD_NONE;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && (PRESCALE > 1)) |=> !strobe.tick); // R2

  AST_LOAD_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countLoad && (PRESCALE > 1)) |=> !strobe.tick); // R2

endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmr_strobe_t       strobe,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              timerIrq
);

  logic [DATA_W-1:0] countQ;
  logic [DATA_W-1:0] compareQ;
  logic [DATA_W-1:0] countStep;
  logic              irqQ;
  logic              matchNow;

  always_comb begin
    countStep = countQ + DATA_W'(1);
    // match only on a prescaler step; loads of either register mask it
    matchNow  = strobe.tick && !strobe.countLoad && !strobe.compareLoad &&
                (countStep == compareQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.countLoad) begin
      countQ <= regWrData;
    end else if (strobe.tick) begin
      countQ <= countStep;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      compareQ <= '0;
    end else if (strobe.compareLoad) begin
      compareQ <= regWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqQ <= 1'b0;
    end else if (strobe.compareLoad) begin
      irqQ <= 1'b0;
    end else if (matchNow) begin
      irqQ <= 1'b1;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      RD_COUNT:   regRdData = countQ;
      RD_COMPARE: regRdData = compareQ;
      default:    regRdData = '0;
    endcase
  end

  assign timerIrq = irqQ;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && !strobe.countLoad) |=> (countQ == $past(countQ) + DATA_W'(1))); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.tick && !strobe.countLoad) |=> $stable(countQ)); // R2

  AST_IRQ_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> (countQ == compareQ)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqQ && !strobe.compareLoad) |=> irqQ); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.compareLoad |=> !irqQ); // R8

  AST_LOAD_NO_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.countLoad && !irqQ) |=> !irqQ); // R9

endmodule

// File: rtl/tick_match_timer.sv
module tick_match_timer
  import tmr_pkg::*;
#(
  parameter int PRESCALE = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              timerIrq
);

  tmr_strobe_t strobe;

  tmr_ctrl #(
    .PRESCALE(PRESCALE),
    .ADDR_W  (ADDR_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regWrEn(regWrEn),
    .regAddr(regAddr),
    .strobe (strobe)
  );

  tmr_datapath #(
    .DATA_W(DATA_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .timerIrq (timerIrq)
  );

  initial begin
    assert (PRESCALE >= 1) else $error("PRESCALE must be at least 1");
  end

endmodule

// File: tb/test_tick_match_timer.sv
`timescale 1ns/1ps
module test_tick_match_timer;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = 5'd9;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        timerIrq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t items[$];

  tick_match_timer #(.PRESCALE(P)) i_tick_match_timer (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .timerIrq(timerIrq)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations against the ports at their due cycle
  always @(negedge clk) begin
    for (int i = items.size() - 1; i >= 0; i--) begin
      if (items[i].due == cyc) begin
        if (items[i].isIrq) check(items[i].tag, {31'd0, timerIrq}, items[i].exp);
        else                check(items[i].tag, regRdData, items[i].exp);
        items.delete(i);
      end
    end
  end

  task automatic expectAt(int dly, bit isIrq, logic [31:0] v, string tag);
    item_t it;
    it.due = cyc + dly; it.isIrq = isIrq; it.exp = v; it.tag = tag;
    items.push_back(it);
  endtask

  // called just after an edge; the write lands on the next edge
  task automatic regWrite(logic [4:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWrEn = 1'b0; regAddr = 5'd9;
  endtask

  task automatic readCheck(logic [4:0] a, logic [31:0] exp, string tag);
    regAddr = a; #1;
    check(tag, regRdData, exp);
    @(posedge clk); #1;
    regAddr = 5'd9;
  endtask

  task automatic drain();
    while (items.size() != 0) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 count in reset", regRdData, 32'd0);
    check("R1 irq in reset", {31'd0, timerIrq}, 32'd0);
    regAddr = 5'd11; #1;
    check("R1 compare in reset", regRdData, 32'd0);
    regAddr = 5'd9;
    @(posedge clk); #1;
    rstN = 1'b1;
    @(posedge clk); #1;

    // R5 / R4 / R10: register access
    regWrite(5'd11, 32'h1234_5678);
    readCheck(5'd11, 32'h1234_5678, "R5 compare readback");
    regWrite(5'd12, 32'hDEAD_BEEF);
    readCheck(5'd12, 32'd0, "R4 unmapped reads zero");
    readCheck(5'd11, 32'h1234_5678, "R10 unmapped write ignored");
    check("R10 irq after unmapped write", {31'd0, timerIrq}, 32'd0);

    // R2 prescaled stepping after a counter load
    regWrite(5'd9, 32'd100);
    expectAt(0, 0, 32'd100, "R2 count loaded");
    expectAt(P - 1, 0, 32'd100, "R2 count held before tick");
    expectAt(P, 0, 32'd101, "R2 first step");
    expectAt(3 * P, 0, 32'd103, "R2 third step");
    expectAt(3 * P, 1, 32'd0, "R6 no irq without match");
    drain();

    // R6 / R7 match after 5 steps, sticky
    regWrite(5'd11, 32'd105);
    regWrite(5'd9, 32'd100);
    expectAt(5 * P - 1, 1, 32'd0, "R6 irq low before match");
    expectAt(5 * P, 1, 32'd1, "R6 irq at match");
    expectAt(5 * P, 0, 32'd105, "R6 count at match");
    expectAt(5 * P + 7, 1, 32'd1, "R7 irq sticky");
    drain();
    regWrite(5'd11, 32'd300);
    expectAt(0, 1, 32'd0, "R7 compare write clears");
    drain();
    readCheck(5'd11, 32'd300, "R5 compare readback 2");

    // R6 shorter interval
    regWrite(5'd11, 32'd52);
    regWrite(5'd9, 32'd50);
    expectAt(2 * P - 1, 1, 32'd0, "R6 short interval early");
    expectAt(2 * P, 1, 32'd1, "R6 short interval match");
    drain();
    regWrite(5'd11, 32'd1000);
    expectAt(0, 1, 32'd0, "R7 clear 2");
    drain();

    // R3 wrap
    regWrite(5'd11, 32'd1);
    regWrite(5'd9, 32'hFFFF_FFFE);
    expectAt(P, 0, 32'hFFFF_FFFF, "R3 top value");
    expectAt(2 * P, 0, 32'd0, "R3 wrap to zero");
    expectAt(3 * P - 1, 1, 32'd0, "R3 irq before wrapped match");
    expectAt(3 * P, 1, 32'd1, "R3 irq after wrap match");
    drain();
    regWrite(5'd11, 32'h0001_0000);
    expectAt(0, 1, 32'd0, "R7 clear 3");
    drain();

    // R8 compare write collides with match edge
    regWrite(5'd11, 32'd500);
    regWrite(5'd9, 32'd499);
    repeat (P - 1) @(posedge clk);
    #1;
    regWrite(5'd11, 32'd500);
    expectAt(0, 0, 32'd500, "R8 count stepped onto match");
    expectAt(0, 1, 32'd0, "R8 write wins");
    expectAt(2, 1, 32'd0, "R8 still clear");
    drain();

    // R9 counter load equal to compare
    regWrite(5'd11, 32'd700);
    regWrite(5'd9, 32'd700);
    expectAt(0, 0, 32'd700, "R9 loaded equal");
    expectAt(1, 1, 32'd0, "R9 no irq on load");
    expectAt(2 * P, 1, 32'd0, "R9 no irq later");
    expectAt(2 * P, 0, 32'd702, "R9 count moves on");
    drain();

    // R9 counter load masks a pending step onto the match
    regWrite(5'd11, 32'd800);
    regWrite(5'd9, 32'd799);
    repeat (P - 1) @(posedge clk);
    #1;
    regWrite(5'd9, 32'd900);
    expectAt(0, 0, 32'd900, "R9 load beats step");
    expectAt(0, 1, 32'd0, "R9 masked match");
    expectAt(P + 1, 1, 32'd0, "R9 masked match later");
    drain();

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule